// File: doc/BRIEF.md
# Sequential Shift-Add Signed-Magnitude Multiplier

This block multiplies two signed-magnitude operands of WIDTH bits each over several clock cycles. It uses one adder. A pulse on `start` while the block is idle captures the multiplicand magnitude and sign and the multiplier magnitude and sign. It clears the partial-product half and its carry bit, and it loads a down-counter with WIDTH. The product sign is taken as the exclusive-OR of the two operand signs.

The block then handles one multiplier bit per pair of cycles, starting from the least significant bit. In the first cycle of a pair it looks at the lowest bit of the low product half. If that bit is set, the multiplicand is added into the high half and the carry is kept in an extra flip-flop. If the bit is clear, no addition is made. In the second cycle the whole carry, high-half and low-half chain shifts one place to the right, and the counter counts down. The partial product is shifted; the multiplicand stays where it is. When the counter reaches zero, one final cycle forces the sign positive if the magnitude is zero. The block then pulses `done`.

The 2*WIDTH-bit magnitude and its sign stay on the outputs until the next accepted `start`. A parameter selects either a ripple-carry adder or an inferred adder.

Top module: `sm_shift_mul`

## Requirements
- R1: After reset, `busy`, `done`, `prod_sign` and every bit of `prod_mag` are 0.
- R2: When `done` is high, `prod_mag` equals the unsigned product of the multiplicand and multiplier magnitudes captured at the accepted `start`. The high WIDTH bits of `prod_mag` are the high half of the product.
- R3: When `done` is high and `prod_mag` is nonzero, `prod_sign` equals the exclusive-OR of the two captured signs, where 1 means negative.
- R4: When `done` is high and `prod_mag` is zero, `prod_sign` is 0, whatever the operand signs were.
- R5: `done` rises exactly 2*WIDTH+1 clock edges after the edge that accepts `start`: one add cycle and one shift cycle per multiplier bit, plus one finishing cycle.
- R6: `done` is high for exactly one cycle per operation.
- R7: `start` is ignored while `busy` is high. Operand inputs that change during an operation do not alter its result or its latency.
- R8: `busy` is high from the edge that accepts `start` until the edge that raises `done`, and it is low while `done` is high.
- R9: While idle with `start` low, `prod_mag` and `prod_sign` hold their values.
- R10: WIDTH below 2 and an ADDER_RIPPLE value other than 0 or 1 are rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; sampled only while idle |
| mcand_mag | input | WIDTH | Multiplicand magnitude |
| mcand_sign | input | 1 | Multiplicand sign, 1 = negative |
| mplier_mag | input | WIDTH | Multiplier magnitude |
| mplier_sign | input | 1 | Multiplier sign, 1 = negative |
| prod_mag | output | 2*WIDTH | Product magnitude, high half then low half |
| prod_sign | output | 1 | Product sign, 1 = negative |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the product is ready |

## Verification
The bound checker runs on every cycle. It checks that `done` is a single-cycle pulse that never overlaps `busy`, and it counts cycles to confirm the exact latency. It also compares each finished magnitude and sign against operands it records itself when a `start` is accepted, and it confirms that results hold while the block is idle. Some behaviour can only be shown by the directed scenarios. These include the reset values, specific corner operands such as full-scale magnitudes, zero with negative signs, and single-bit patterns, and the fact that a `start` pulse and changed operands in mid-operation leave the result intact.

// File: rtl/sm_mul_pkg.sv
package sm_mul_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_ADD   = 2'd1,
      PH_SHIFT = 2'd2,
      PH_FIX   = 2'd3
   } phase_t;
endpackage

// File: rtl/sm_mul_adder.sv
module sm_mul_adder #(
   parameter int WIDTH        = 8,
   parameter int ADDER_RIPPLE = 1
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   output logic [WIDTH-1:0] sum,
   output logic             carry
);
   generate
      if (ADDER_RIPPLE == 1) begin : g_ripple
         logic [WIDTH:0] c;
         assign c[0] = 1'b0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]  = op_a[i] ^ op_b[i] ^ c[i];
            assign c[i+1]  = (op_a[i] & op_b[i]) | (c[i] & (op_a[i] ^ op_b[i]));
         end
         assign carry = c[WIDTH];
      end else begin : g_infer
         logic [WIDTH:0] full;
         assign full  = {1'b0, op_a} + {1'b0, op_b};
         assign sum   = full[WIDTH-1:0];
         assign carry = full[WIDTH];
      end
   endgenerate
endmodule

// File: rtl/sm_mul_ctrl.sv
module sm_mul_ctrl
   import sm_mul_pkg::*;
#(
   parameter int WIDTH = 8,
   localparam int CW   = $clog2(WIDTH + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic ld_en,
   output logic add_en,
   output logic shift_en,
   output logic fix_en,
   output logic busy,
   output logic done
);
   localparam logic [CW-1:0] BITS = CW'(WIDTH);

   phase_t        phase_q, phase_d;
   logic [CW-1:0] seq_q;
   logic          done_q;

   assign ld_en    = (phase_q == PH_IDLE) && start;
   assign add_en   = (phase_q == PH_ADD);
   assign shift_en = (phase_q == PH_SHIFT);
   assign fix_en   = (phase_q == PH_FIX);
   assign busy     = (phase_q != PH_IDLE);
   assign done     = done_q;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE:  if (start) phase_d = PH_ADD;
         PH_ADD:   phase_d = PH_SHIFT;
         PH_SHIFT: phase_d = (seq_q == CW'(1)) ? PH_FIX : PH_ADD;
         PH_FIX:   phase_d = PH_IDLE;
         default:  phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         seq_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done_q  <= (phase_q == PH_FIX);
         if (ld_en)         seq_q <= BITS;
         else if (shift_en) seq_q <= seq_q - CW'(1);
      end
   end
endmodule

// File: rtl/sm_mul_datapath.sv
module sm_mul_datapath #(
   parameter int WIDTH        = 8,
   parameter int ADDER_RIPPLE = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_en,
   input  logic               add_en,
   input  logic               shift_en,
   input  logic               fix_en,
   input  logic [WIDTH-1:0]   mcand_mag,
   input  logic               mcand_sign,
   input  logic [WIDTH-1:0]   mplier_mag,
   input  logic               mplier_sign,
   output logic [2*WIDTH-1:0] prod_mag,
   output logic               prod_sign
);
   logic [WIDTH-1:0] hi_q, lo_q, mc_q;
   logic             cy_q, sgn_q;
   logic [WIDTH-1:0] add_sum;
   logic             add_cy;

   sm_mul_adder #(.WIDTH(WIDTH), .ADDER_RIPPLE(ADDER_RIPPLE)) u_add (
      .op_a  (hi_q),
      .op_b  (mc_q),
      .sum   (add_sum),
      .carry (add_cy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q  <= '0;
         lo_q  <= '0;
         mc_q  <= '0;
         cy_q  <= 1'b0;
         sgn_q <= 1'b0;
      end else if (ld_en) begin
         mc_q  <= mcand_mag;
         lo_q  <= mplier_mag;
         hi_q  <= '0;
         cy_q  <= 1'b0;
         sgn_q <= mcand_sign ^ mplier_sign;
      end else if (add_en) begin
         if (lo_q[0]) begin
            hi_q <= add_sum;
            cy_q <= add_cy;
         end
      end else if (shift_en) begin
         {cy_q, hi_q, lo_q} <= {1'b0, cy_q, hi_q, lo_q[WIDTH-1:1]};
      end else if (fix_en) begin
         if ({hi_q, lo_q} == '0) sgn_q <= 1'b0;
      end
   end

   assign prod_mag  = {hi_q, lo_q};
   assign prod_sign = sgn_q;
endmodule

// File: rtl/sm_shift_mul.sv
module sm_shift_mul #(
   parameter int WIDTH        = 8,
   parameter int ADDER_RIPPLE = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [WIDTH-1:0]   mcand_mag,
   input  logic               mcand_sign,
   input  logic [WIDTH-1:0]   mplier_mag,
   input  logic               mplier_sign,
   output logic [2*WIDTH-1:0] prod_mag,
   output logic               prod_sign,
   output logic               busy,
   output logic               done
);
   // R10: parameter legality
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("sm_shift_mul: WIDTH must be at least 2");
      end
      if (ADDER_RIPPLE != 0 && ADDER_RIPPLE != 1) begin : g_bad_adder
         $error("sm_shift_mul: ADDER_RIPPLE must be 0 or 1");
      end
   endgenerate

   logic ld_en, add_en, shift_en, fix_en;

   sm_mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .ld_en    (ld_en),
      .add_en   (add_en),
      .shift_en (shift_en),
      .fix_en   (fix_en),
      .busy     (busy),
      .done     (done)
   );

   sm_mul_datapath #(.WIDTH(WIDTH), .ADDER_RIPPLE(ADDER_RIPPLE)) u_dp (
      .clk         (clk),
      .rst_n       (rst_n),
      .ld_en       (ld_en),
      .add_en      (add_en),
      .shift_en    (shift_en),
      .fix_en      (fix_en),
      .mcand_mag   (mcand_mag),
      .mcand_sign  (mcand_sign),
      .mplier_mag  (mplier_mag),
      .mplier_sign (mplier_sign),
      .prod_mag    (prod_mag),
      .prod_sign   (prod_sign)
   );
endmodule

// File: rtl/sm_shift_mul_chk.sv
module sm_shift_mul_chk #(
   parameter int WIDTH = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic [WIDTH-1:0]   mcand_mag,
   input logic               mcand_sign,
   input logic [WIDTH-1:0]   mplier_mag,
   input logic               mplier_sign,
   input logic [2*WIDTH-1:0] prod_mag,
   input logic               prod_sign,
   input logic               busy,
   input logic               done
);
   localparam int LAT = 2 * WIDTH + 1;
   localparam int LW  = $clog2(LAT + 2) + 1;

   logic [LW-1:0]      lat_cnt;
   logic [2*WIDTH-1:0] exp_mag;
   logic               exp_sgn;
   logic               accept;

   assign accept = start && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_cnt <= '0;
         exp_mag <= '0;
         exp_sgn <= 1'b0;
      end else begin
         if (accept) begin
            lat_cnt <= '0;
            exp_mag <= (2*WIDTH)'(mcand_mag) * (2*WIDTH)'(mplier_mag);
            exp_sgn <= mcand_sign ^ mplier_sign;
         end else if (busy) begin
            lat_cnt <= lat_cnt + LW'(1);
         end
      end
   end

   // R2
   product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> prod_mag == exp_mag);
   // R3
   product_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && prod_mag != '0) |-> prod_sign == exp_sgn);
   // R4
   zero_positive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && prod_mag == '0) |-> !prod_sign);
   // R5
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> lat_cnt == LW'(LAT));
   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R8
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy);
   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(prod_mag) && $stable(prod_sign)));
endmodule

bind sm_shift_mul sm_shift_mul_chk #(.WIDTH(WIDTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .mcand_mag   (mcand_mag),
   .mcand_sign  (mcand_sign),
   .mplier_mag  (mplier_mag),
   .mplier_sign (mplier_sign),
   .prod_mag    (prod_mag),
   .prod_sign   (prod_sign),
   .busy        (busy),
   .done        (done)
);

// File: tb/sm_shift_mul_tb.sv
`timescale 1ns/1ps
module sm_shift_mul_tb;
   localparam int W   = 8;
   localparam int LAT = 2 * W + 1;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [W-1:0]   mcand_mag = '0, mplier_mag = '0;
   logic           mcand_sign = 1'b0, mplier_sign = 1'b0;
   logic [2*W-1:0] prod_mag;
   logic           prod_sign, busy, done;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   sm_shift_mul #(.WIDTH(W), .ADDER_RIPPLE(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .mcand_mag(mcand_mag), .mcand_sign(mcand_sign),
      .mplier_mag(mplier_mag), .mplier_sign(mplier_sign),
      .prod_mag(prod_mag), .prod_sign(prod_sign),
      .busy(busy), .done(done)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Launch an operation; disturb = pulse start with other operands mid-run.
   task automatic run_op(input logic [W-1:0] a, input bit as_, input logic [W-1:0] b,
                         input bit bs_, input bit disturb);
      longint exp_mag;
      bit     exp_sgn;
      int     cyc;
      int     pulses;
      exp_mag = longint'(a) * longint'(b);
      exp_sgn = (exp_mag == 0) ? 1'b0 : (as_ ^ bs_);
      @(negedge clk);
      mcand_mag = a; mcand_sign = as_; mplier_mag = b; mplier_sign = bs_;
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      check(busy == 1'b1, "R8 busy after accept", busy, 1);
      cyc = 0;
      while (!done && cyc < 100) begin
         if (disturb && cyc == 3) begin
            start = 1'b1;
            mcand_mag = ~a; mplier_mag = ~b; mcand_sign = ~as_;
         end
         if (disturb && cyc == 6) start = 1'b0;
         if (!done) check(busy == 1'b1, "R8 busy during run", busy, 1);
         @(posedge clk); #1;
         cyc++;
      end
      start = 1'b0;
      check(cyc == LAT, disturb ? "R7 latency with ignored start" : "R5 latency", cyc, LAT);
      check(prod_mag == exp_mag[2*W-1:0], disturb ? "R7 product with ignored start" : "R2 product",
            prod_mag, exp_mag);
      if (exp_mag == 0) check(prod_sign == 1'b0, "R4 zero sign", prod_sign, 0);
      else              check(prod_sign == exp_sgn, "R3 sign", prod_sign, exp_sgn);
      check(busy == 1'b0, "R8 idle at done", busy, 0);
      pulses = 0;
      @(posedge clk); #1;
      check(done == 1'b0, "R6 done single cycle", done, 0);
   endtask

   task automatic t_reset();
      check(busy == 0 && done == 0, "R1 control reset", {busy, done}, 0);
      check(prod_mag == 0 && prod_sign == 0, "R1 product reset", {prod_sign, prod_mag}, 0);
   endtask

   task automatic t_patterns();
      run_op(8'd13, 1'b0, 8'd11, 1'b0, 1'b0);
      run_op(8'hFF, 1'b1, 8'hFF, 1'b0, 1'b0);
      run_op(8'd1,  1'b1, 8'd1,  1'b1, 1'b0);
      run_op(8'h80, 1'b0, 8'h81, 1'b1, 1'b0);
      run_op(8'hAA, 1'b1, 8'h55, 1'b0, 1'b0);
   endtask

   task automatic t_zero_sign();
      run_op(8'd0,  1'b1, 8'd77, 1'b0, 1'b0);
      run_op(8'd42, 1'b0, 8'd0,  1'b1, 1'b0);
   endtask

   task automatic t_ignored_start();
      run_op(8'd5, 1'b0, 8'd7, 1'b1, 1'b1);
   endtask

   task automatic t_hold();
      logic [2*W-1:0] m;
      logic           s;
      m = prod_mag; s = prod_sign;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         mcand_mag = 8'(i * 37); mplier_mag = 8'(i + 3); mcand_sign = i[0];
      end
      @(posedge clk); #1;
      check(prod_mag == m, "R9 magnitude held", prod_mag, m);
      check(prod_sign == s && busy == 0, "R9 sign held", prod_sign, s);
   endtask

   initial begin
      #2000000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #12;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_patterns();
      t_zero_sign();
      t_ignored_start();
      t_hold();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule